// File: doc/BRIEF.md
# Polled Byte Transfer Controller

This block sits between a host that works by polling and a byte-wide peripheral. The host uses a small register bus to load an outgoing byte, choose a direction and raise a start flag. It then reads a status register until the controller reports that the transfer is over. Each command moves exactly one byte. A write offers the held byte to the peripheral. A read takes one byte from the peripheral and stores it in a receive register.

The peripheral side is a pair of valid/ready handshakes, one for each direction. Only the direction selected by the current command is active, and only while the command is in progress. A programmable cycle limit stops a transfer that the peripheral never completes and marks it as failed. A sticky flag records when a received byte has replaced one the host never read.

Top module: `pdc_ctrl`

## Requirements
- R1: After reset, the status, outgoing and incoming byte registers read 0, the timeout register reads TMO_RST (default 8), and neither peripheral handshake output is asserted.
- R2: Register select 0 is status/control: bit0 start flag, bit1 direction (1 = write to peripheral), bit2 busy, bit3 error, bit4 overrun, and bits 5 and up read 0. Select 1 is the outgoing byte, select 2 is the incoming byte and select 3 is the timeout limit. Read data appears on hb_rdata in the cycle after the read strobe.
- R3: When the start flag is 1 and the block is idle, busy is 1 from the next cycle. While busy, a write command drives dev_tx_valid with the outgoing byte on dev_tx_data, and a read command drives dev_rx_ready.
- R4: A completed write handshake clears busy, error and the start flag at the same clock edge, and the peripheral receives the outgoing byte.
- R5: A completed read handshake places the peripheral's byte in the incoming register at the same edge that busy clears.
- R6: If no handshake completes within T busy cycles (T = timeout register, 0 behaves as 1), busy and the start flag clear and error is set. A handshake in the T-th cycle completes normally.
- R7: Error stays 1 after a timeout until the next successful transfer clears it.
- R8: While the start flag is 1 (a command is pending or in progress), host writes to the status, outgoing byte and timeout registers have no effect.
- R9: A read completion while the incoming byte is still unread sets overrun, and the new byte replaces the old one. A host read of select 2 marks the byte as read.
- R10: Overrun stays set until the host reads the status register. If a new overrun occurs in the same cycle as that read, the flag stays set.
- R11: The peripheral handshake outputs are asserted only while busy, and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_wr_en | input | 1 | Host register write strobe |
| hb_rd_en | input | 1 | Host register read strobe |
| hb_addr | input | 2 | Host register select |
| hb_wdata | input | DATA_W | Host write data |
| hb_rdata | output | DATA_W | Registered host read data |
| dev_tx_valid | output | 1 | Outgoing byte offered to peripheral |
| dev_tx_ready | input | 1 | Peripheral accepts outgoing byte |
| dev_tx_data | output | DATA_W | Outgoing byte |
| dev_rx_valid | input | 1 | Peripheral presents a byte |
| dev_rx_ready | output | 1 | Controller will take a byte |
| dev_rx_data | input | DATA_W | Byte from peripheral |

## Verification
The assertions check several rules on every cycle:
- A pending start always leads to busy on the next cycle.
- A handshake ends busy with error clear.
- A read handshake lands its byte in the incoming register.
- Error only rises as busy falls.
- The outgoing byte never changes while a command is held.
- An unread byte that is overwritten raises overrun.
- The two handshake directions stay exclusive and confined to busy.

Only the bench scenarios can show the rest:
- The exact timeout boundary, including a handshake in the last allowed cycle and a zero limit.
- That error persists across commands until a success clears it.
- That host writes made during a transfer are dropped, as seen through the register reads.
- The read-to-clear behaviour of overrun.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int unsigned REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_STAT = 2'd0,
    REG_DOUT = 2'd1,
    REG_DIN  = 2'd2,
    REG_TMO  = 2'd3
  } reg_sel_e;

  localparam int BIT_CMD  = 0;
  localparam int BIT_DIR  = 1;
  localparam int BIT_BUSY = 2;
  localparam int BIT_ERR  = 3;
  localparam int BIT_OVR  = 4;
endpackage

// File: rtl/pdc_seq.sv
// Command sequencer: start flag, direction, busy, error and the abort timer.
module pdc_seq #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr_stat,
  input  logic             wr_cmd,
  input  logic             wr_dir,
  input  logic [TMO_W-1:0] tmo_lim,
  input  logic             xfer_done,
  output logic             cmd_q,
  output logic             dir_q,
  output logic             busy_q,
  output logic             err_q
);
  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W:0]   cnt_nxt;
  logic             expire;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
  assign expire  = (cnt_nxt >= {1'b0, tmo_lim});

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= 1'b0;
      dir_q  <= 1'b0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (xfer_done) begin
        busy_q <= 1'b0;
        cmd_q  <= 1'b0;
        err_q  <= 1'b0;
        cnt_q  <= '0;
      end else if (expire) begin
        busy_q <= 1'b0;
        cmd_q  <= 1'b0;
        err_q  <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_nxt[TMO_W-1:0];
      end
    end else if (cmd_q) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (host_wr_stat) begin
      cmd_q <= wr_cmd;
      dir_q <= wr_dir;
    end
  end
endmodule

// File: rtl/pdc_rxbuf.sv
// Incoming byte register with unread tracking and sticky overrun flag.
module pdc_rxbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              rd_din,
  input  logic              rd_stat,
  output logic [DATA_W-1:0] din_q,
  output logic              full_q,
  output logic              ovr_q
);
  logic lost;

  assign lost = cap && full_q && !rd_din;

  always_ff @(posedge clk) begin
    if (rst) begin
      din_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (cap) begin
        din_q  <= cap_data;
        full_q <= 1'b1;
      end else if (rd_din) begin
        full_q <= 1'b0;
      end
      if (lost) begin
        ovr_q <= 1'b1;
      end else if (rd_stat) begin
        ovr_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pdc_ctrl.sv
module pdc_ctrl
  import pdc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int TMO_W   = 8,
  parameter int TMO_RST = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hb_wr_en,
  input  logic              hb_rd_en,
  input  logic [REG_AW-1:0] hb_addr,
  input  logic [DATA_W-1:0] hb_wdata,
  output logic [DATA_W-1:0] hb_rdata,
  output logic              dev_tx_valid,
  input  logic              dev_tx_ready,
  output logic [DATA_W-1:0] dev_tx_data,
  input  logic              dev_rx_valid,
  output logic              dev_rx_ready,
  input  logic [DATA_W-1:0] dev_rx_data
);
  reg_sel_e          sel;
  logic              cmd_q, dir_q, busy_q, err_q;
  logic              full_q, ovr_q;
  logic [DATA_W-1:0] dout_q, din_q, rdata_q, stat_w;
  logic [TMO_W-1:0]  tmo_q;
  logic              wr_ok, wr_stat, tx_fire, rx_fire, rd_stat, rd_din;

  assign sel     = reg_sel_e'(hb_addr);
  assign wr_ok   = hb_wr_en && !cmd_q;
  assign wr_stat = wr_ok && (sel == REG_STAT);
  assign rd_stat = hb_rd_en && (sel == REG_STAT);
  assign rd_din  = hb_rd_en && (sel == REG_DIN);

  assign dev_tx_valid = busy_q && dir_q;
  assign dev_rx_ready = busy_q && !dir_q;
  assign dev_tx_data  = dout_q;
  assign tx_fire      = dev_tx_valid && dev_tx_ready;
  assign rx_fire      = dev_rx_ready && dev_rx_valid;

  pdc_seq #(.TMO_W(TMO_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .host_wr_stat(wr_stat),
    .wr_cmd      (hb_wdata[BIT_CMD]),
    .wr_dir      (hb_wdata[BIT_DIR]),
    .tmo_lim     (tmo_q),
    .xfer_done   (tx_fire || rx_fire),
    .cmd_q       (cmd_q),
    .dir_q       (dir_q),
    .busy_q      (busy_q),
    .err_q       (err_q)
  );

  pdc_rxbuf #(.DATA_W(DATA_W)) u_rxbuf (
    .clk     (clk),
    .rst     (rst),
    .cap     (rx_fire),
    .cap_data(dev_rx_data),
    .rd_din  (rd_din),
    .rd_stat (rd_stat),
    .din_q   (din_q),
    .full_q  (full_q),
    .ovr_q   (ovr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      tmo_q  <= TMO_W'(TMO_RST);
    end else if (wr_ok) begin
      if (sel == REG_DOUT) dout_q <= hb_wdata;
      if (sel == REG_TMO)  tmo_q  <= TMO_W'(hb_wdata);
    end
  end

  always_comb begin
    stat_w           = '0;
    stat_w[BIT_CMD]  = cmd_q;
    stat_w[BIT_DIR]  = dir_q;
    stat_w[BIT_BUSY] = busy_q;
    stat_w[BIT_ERR]  = err_q;
    stat_w[BIT_OVR]  = ovr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (hb_rd_en) begin
      case (sel)
        REG_STAT: rdata_q <= stat_w;
        REG_DOUT: rdata_q <= dout_q;
        REG_DIN:  rdata_q <= din_q;
        default:  rdata_q <= DATA_W'(tmo_q);
      endcase
    end
  end

  assign hb_rdata = rdata_q;
endmodule

// File: rtl/pdc_ctrl_chk.sv
module pdc_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_q,
  input logic              busy_q,
  input logic              err_q,
  input logic              full_q,
  input logic              ovr_q,
  input logic              rd_din,
  input logic [DATA_W-1:0] dout_q,
  input logic [DATA_W-1:0] din_q,
  input logic              dev_tx_valid,
  input logic              dev_tx_ready,
  input logic              dev_rx_valid,
  input logic              dev_rx_ready,
  input logic [DATA_W-1:0] dev_rx_data
);
  // R3
  start_to_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q && !busy_q) |=> busy_q);

  // R4
  tx_done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && dev_tx_valid && dev_tx_ready) |=> (!busy_q && !err_q && !cmd_q));

  // R5
  rx_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && dev_rx_ready && dev_rx_valid) |=> (!busy_q && din_q == $past(dev_rx_data)));

  // R6
  err_on_abort_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $fell(busy_q));

  // R8
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_q |=> $stable(dout_q));

  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (dev_rx_ready && dev_rx_valid && full_q && !rd_din) |=> ovr_q);

  // R11
  dir_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(dev_tx_valid && dev_rx_ready));

  // R11
  hs_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (dev_tx_valid || dev_rx_ready) |-> busy_q);
endmodule

bind pdc_ctrl pdc_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_q       (cmd_q),
  .busy_q      (busy_q),
  .err_q       (err_q),
  .full_q      (full_q),
  .ovr_q       (ovr_q),
  .rd_din      (rd_din),
  .dout_q      (dout_q),
  .din_q       (din_q),
  .dev_tx_valid(dev_tx_valid),
  .dev_tx_ready(dev_tx_ready),
  .dev_rx_valid(dev_rx_valid),
  .dev_rx_ready(dev_rx_ready),
  .dev_rx_data (dev_rx_data)
);

// File: tb/pdc_ctrl_bench.sv
module pdc_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hb_wr_en = 1'b0, hb_rd_en = 1'b0;
  logic [1:0] hb_addr = 2'd0;
  logic [7:0] hb_wdata = 8'd0;
  logic [7:0] hb_rdata;
  logic       dev_tx_valid, dev_rx_ready;
  logic       dev_tx_ready = 1'b0, dev_rx_valid = 1'b0;
  logic [7:0] dev_tx_data;
  logic [7:0] dev_rx_data = 8'd0;

  int checks = 0, failures = 0;
  int dly_cfg = 0, act_cnt = 0;
  int n_tx = 0, n_rx = 0, tx_vcyc = 0;
  logic [7:0] got_tx = 8'd0;
  bit finished = 0;

  // {dir, byte, delay}; delay = peripheral wait cycles before handshake
  localparam logic [12:0] VEC [0:7] = '{
    {1'b1, 8'hA5, 4'd0}, {1'b0, 8'h3C, 4'd1}, {1'b1, 8'hFF, 4'd4},
    {1'b0, 8'h00, 4'd7}, {1'b1, 8'h5A, 4'd9}, {1'b0, 8'h81, 4'd7},
    {1'b1, 8'h01, 4'd2}, {1'b0, 8'hC3, 4'd8}};

  always #4 clk = ~clk;

  pdc_ctrl u_pdc_ctrl (
    .clk(clk), .rst(rst), .hb_wr_en(hb_wr_en), .hb_rd_en(hb_rd_en),
    .hb_addr(hb_addr), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata),
    .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready),
    .dev_tx_data(dev_tx_data), .dev_rx_valid(dev_rx_valid),
    .dev_rx_ready(dev_rx_ready), .dev_rx_data(dev_rx_data));

  // peripheral model: completes the handshake after dly_cfg busy cycles
  always @(negedge clk) begin
    dev_tx_ready = 1'b0;
    dev_rx_valid = 1'b0;
    if (rst || !(dev_tx_valid || dev_rx_ready)) begin
      act_cnt = 0;
    end else begin
      if (act_cnt == dly_cfg) begin
        if (dev_tx_valid) dev_tx_ready = 1'b1;
        else dev_rx_valid = 1'b1;
      end
      act_cnt++;
    end
  end

  always @(posedge clk) begin
    if (dev_tx_valid) tx_vcyc++;
    if (dev_tx_valid && dev_tx_ready) begin got_tx = dev_tx_data; n_tx++; end
    if (dev_rx_ready && dev_rx_valid) n_rx++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); hb_wr_en = 1'b1; hb_addr = a; hb_wdata = d;
    @(negedge clk); hb_wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); hb_rd_en = 1'b1; hb_addr = a;
    @(negedge clk); hb_rd_en = 1'b0; d = hb_rdata;
  endtask

  task automatic poll_done(output logic [7:0] s);
    for (int i = 0; i < 200; i++) begin
      bus_rd(2'd0, s);
      if (!s[0] && !s[2]) return;
    end
    check("R3 poll timeout", 32'd1, 32'd0);
  endtask

  task automatic run_cmd(input logic dir, input logic [7:0] b, input int dly,
                         output logic [7:0] s);
    dly_cfg = dly;
    dev_rx_data = b;
    if (dir) bus_wr(2'd1, b);
    bus_wr(2'd0, {6'd0, dir, 1'b1});
    poll_done(s);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d;
    int ntx0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 tx_valid idle", {31'd0, dev_tx_valid}, 32'd0);
    check("R1 rx_ready idle", {31'd0, dev_rx_ready}, 32'd0);
    bus_rd(2'd0, s); check("R1 status reset", {24'd0, s}, 32'h00);
    bus_rd(2'd1, d); check("R1 dout reset", {24'd0, d}, 32'h00);
    bus_rd(2'd2, d); check("R1 din reset", {24'd0, d}, 32'h00);
    bus_rd(2'd3, d); check("R1 R2 timeout reset", {24'd0, d}, 32'd8);

    // table walk: timeout limit 8, success iff delay+1 <= 8
    for (int i = 0; i < 8; i++) begin
      logic vdir; logic [7:0] vb; int vd; logic xerr;
      vdir = VEC[i][12]; vb = VEC[i][11:4]; vd = int'(VEC[i][3:0]);
      xerr = (vd + 1 > 8);
      ntx0 = n_tx;
      run_cmd(vdir, vb, vd, s);
      check("R6 R7 error bit", {31'd0, s[3]}, {31'd0, xerr});
      check("R2 status upper bits zero", {29'd0, s[7:5]}, 32'd0);
      if (vdir && !xerr) begin
        check("R4 byte at peripheral", {24'd0, got_tx}, {24'd0, vb});
        check("R4 one transfer", n_tx - ntx0, 32'd1);
      end else if (vdir) begin
        check("R6 no transfer on abort", n_tx - ntx0, 32'd0);
      end else if (!xerr) begin
        bus_rd(2'd2, d);
        check("R5 din captured", {24'd0, d}, {24'd0, vb});
      end
    end

    // R6 boundary with limit 3
    bus_wr(2'd3, 8'd3);
    bus_rd(2'd3, d); check("R2 timeout readback", {24'd0, d}, 32'd3);
    tx_vcyc = 0;
    run_cmd(1'b1, 8'h66, 2, s);
    check("R6 handshake in last cycle wins", {31'd0, s[3]}, 32'd0);
    check("R6 busy cycles success", tx_vcyc, 32'd3);
    tx_vcyc = 0;
    run_cmd(1'b1, 8'h67, 3, s);
    check("R6 abort at limit", {31'd0, s[3]}, 32'd1);
    check("R6 busy cycles abort", tx_vcyc, 32'd3);
    bus_wr(2'd3, 8'd0);
    tx_vcyc = 0;
    run_cmd(1'b1, 8'h68, 5, s);
    check("R6 zero limit aborts", {31'd0, s[3]}, 32'd1);
    check("R6 zero limit one cycle", tx_vcyc, 32'd1);
    bus_wr(2'd3, 8'd8);

    // R3 / R11: read command drives rx_ready the cycle after start
    dly_cfg = 5; dev_rx_data = 8'h99;
    bus_wr(2'd0, 8'h01);
    @(negedge clk);
    check("R3 rx_ready one cycle after start", {31'd0, dev_rx_ready}, 32'd1);
    check("R11 tx_valid off in read", {31'd0, dev_tx_valid}, 32'd0);
    poll_done(s);
    bus_rd(2'd2, d); check("R5 din after directed read", {24'd0, d}, 32'h99);

    // R8: writes during a command are dropped
    dly_cfg = 6;
    bus_wr(2'd1, 8'h11);
    bus_wr(2'd0, 8'h03);
    bus_wr(2'd1, 8'hEE);
    bus_wr(2'd0, 8'h00);
    bus_wr(2'd3, 8'd1);
    ntx0 = n_tx;
    poll_done(s);
    check("R8 peripheral got original byte", {24'd0, got_tx}, 32'h11);
    check("R8 direction kept", {31'd0, s[1]}, 32'd1);
    bus_rd(2'd1, d); check("R8 dout unchanged", {24'd0, d}, 32'h11);
    bus_rd(2'd3, d); check("R8 timeout unchanged", {24'd0, d}, 32'd8);
    repeat (4) @(negedge clk);
    check("R8 no extra transfer", n_tx - ntx0, 32'd1);

    // R9 / R10: two reads without taking the first byte
    run_cmd(1'b0, 8'h21, 1, s);
    check("R9 no overrun on first", {31'd0, s[4]}, 32'd0);
    run_cmd(1'b0, 8'h42, 1, s);
    check("R9 overrun flagged", {31'd0, s[4]}, 32'd1);
    bus_rd(2'd2, d); check("R9 newest byte kept", {24'd0, d}, 32'h42);
    bus_rd(2'd0, s); check("R10 cleared by status read", {31'd0, s[4]}, 32'd0);
    run_cmd(1'b0, 8'h24, 1, s);
    check("R9 no overrun after din read", {31'd0, s[4]}, 32'd0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule